// File: doc/BRIEF.md
# Destination Address CAM Filter

This block decides, for every incoming Ethernet frame, whether the frame should be kept or dropped. It looks only at the destination address. The six address bytes arrive one per valid cycle, and the first byte carries a start-of-frame mark. The block checks the address against a small content-addressable table of station addresses. It also checks it against three address-class switches. One cycle after the sixth byte it raises a one-cycle valid strobe together with an accept/reject result.

Software loads up to sixteen 48-bit station addresses through a simple register write port. Each address needs two word writes. Each entry is switched on by its own bit in an enable register. A command register chooses which address classes are accepted unconditionally. It also sets whether the table comparison takes part, and whether a table hit means keep or drop. All programmed values are copied into a working set when a frame starts, so a frame already being compared never sees a write that lands during it.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are 0, all entries, the enable register and the command register are 0, and so every frame is rejected until software programs the block.
- R2: Entry k is written in two parts. A write to register address 2k loads address bytes 0..3 from data bits 31:0, with byte 0 (the first byte received) in bits 31:24. A write to address 2k+1 loads byte 4 from bits 31:24 and byte 5 from bits 23:16. An entry hits when all 48 bits equal the received address and the entry is enabled.
- R3: The enable register sits at address 2N (32 with 16 entries). Bit k enables entry k, so a disabled entry never hits.
- R4: The command register sits at address 2N+1 (33). Bit 0 accepts every unicast address (bit 0 of byte 0 clear). Bit 1 accepts every multicast address (bit 0 of byte 0 set, not all ones). Bit 2 accepts the broadcast address (all 48 bits set).
- R5: Command bit 3 sets the table polarity. At 0 a table hit accepts the frame; at 1 a table hit rejects it and a miss accepts it.
- R6: Command bit 4 enables table comparison. When it is 0, the table result has no effect and only the class switches decide.
- R7: `dec_valid` is a one-cycle pulse in the cycle after the sixth address byte is taken. `dec_accept` holds the decision from that cycle until the next start-of-frame byte, which clears it to 0.
- R8: A start-of-frame byte before the sixth byte restarts the address from that byte. Bytes with `in_valid` low are ignored, and so are bytes after the sixth until the next start-of-frame.
- R9: Register writes, including one in the same cycle as a start-of-frame byte, affect only frames that start later, never the frame being compared.
- R10: Any of the 16 entries can produce a hit, including the last one (entry 15).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (6) | Register address: entries at 0..2N-1, enable at 2N, command at 2N+1 |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Address byte valid |
| in_sof | input | 1 | Marks the first address byte of a frame |
| in_byte | input | 8 | Destination address byte, byte 0 first |
| dec_valid | output | 1 | One-cycle strobe: decision ready |
| dec_accept | output | 1 | Frame accepted (held until next start-of-frame) |

## Verification
The bench builds the block with the default 16 entries, which gives a 6-bit register address. This puts the enable and command registers at addresses 32 and 33 and lets entry 15 be reached as the outermost case. With the full table present, the bench can check that only the enabled entry hits when several entries are loaded. A behavioural model tracks the programmed and per-frame copies of the registers, so writes that arrive in the middle of a frame are checked against the frame they must not disturb.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;

    localparam int ADDR_BYTES = 6;
    localparam int MAC_W      = 8 * ADDR_BYTES;

    // Command register fields, bit 4 down to bit 0
    typedef struct packed {
        logic cmp_en;     // bit 4: table comparison in use
        logic invert;     // bit 3: table hit rejects
        logic take_bc;    // bit 2: accept broadcast
        logic take_mc;    // bit 1: accept multicast
        logic take_uc;    // bit 0: accept unicast
    } cmd_t;

    typedef enum logic [1:0] {
        CLS_UNI   = 2'd0,
        CLS_MULTI = 2'd1,
        CLS_BCAST = 2'd2
    } addr_cls_e;

    // Byte 0 occupies bits 47:40; its bit 0 is the group bit.
    function automatic addr_cls_e classify(input logic [MAC_W-1:0] a);
        if (&a)        return CLS_BCAST;
        else if (a[40]) return CLS_MULTI;
        else           return CLS_UNI;
    endfunction

    function automatic logic decide(input cmd_t c, input addr_cls_e k,
                                    input logic hit);
        logic cls_ok;
        cls_ok = (c.take_uc && k == CLS_UNI)   ||
                 (c.take_mc && k == CLS_MULTI) ||
                 (c.take_bc && k == CLS_BCAST);
        return cls_ok || (c.cmp_en && (hit ^ c.invert));
    endfunction

endpackage

// File: rtl/dafilt_regs.sv
module dafilt_regs
    import dafilt_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int REG_AW    = 6
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [REG_AW-1:0]               wr_addr,
    input  logic [31:0]                     wr_data,
    input  logic                            snap,
    output logic [N_ENTRIES-1:0][MAC_W-1:0] act_ent,
    output logic [N_ENTRIES-1:0]            act_en,
    output cmd_t                            act_cmd
);
    localparam int EN_ADDR  = 2 * N_ENTRIES;
    localparam int CMD_ADDR = 2 * N_ENTRIES + 1;

    logic [N_ENTRIES-1:0][MAC_W-1:0] prog_ent;
    logic [N_ENTRIES-1:0]            prog_en;
    cmd_t                            prog_cmd;

    for (genvar k = 0; k < N_ENTRIES; k++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                prog_ent[k] <= '0;
            end else if (wr_en && wr_addr == REG_AW'(2 * k)) begin
                prog_ent[k][47:16] <= wr_data;
            end else if (wr_en && wr_addr == REG_AW'(2 * k + 1)) begin
                prog_ent[k][15:0] <= wr_data[31:16];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_en  <= '0;
            prog_cmd <= '0;
        end else if (wr_en) begin
            if (wr_addr == REG_AW'(EN_ADDR))  prog_en  <= wr_data[N_ENTRIES-1:0];
            if (wr_addr == REG_AW'(CMD_ADDR)) prog_cmd <= cmd_t'(wr_data[4:0]);
        end
    end

    // Working copy frozen for the frame that starts now
    always_ff @(posedge clk) begin
        if (rst) begin
            act_ent <= '0;
            act_en  <= '0;
            act_cmd <= '0;
        end else if (snap) begin
            act_ent <= prog_ent;
            act_en  <= prog_en;
            act_cmd <= prog_cmd;
        end
    end
endmodule

// File: rtl/dafilt_capture.sv
module dafilt_capture
    import dafilt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [7:0]       in_byte,
    output logic [MAC_W-1:0] addr_full,
    output logic             addr_done
);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] IDLE = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

    logic [CNT_W-1:0]       cnt;
    logic [MAC_W-9:0]       head;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= IDLE;
            head <= '0;
        end else if (in_valid && in_sof) begin
            cnt  <= CNT_W'(1);
            head <= {head[MAC_W-17:0], in_byte};
        end else if (in_valid && cnt != IDLE) begin
            cnt  <= cnt + 1'b1;
            head <= {head[MAC_W-17:0], in_byte};
        end
    end

    assign addr_full = {head, in_byte};
    assign addr_done = in_valid && !in_sof && cnt == LAST;
endmodule

// File: rtl/dafilt_match.sv
module dafilt_match
    import dafilt_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input  logic [N_ENTRIES-1:0][MAC_W-1:0] ent,
    input  logic [N_ENTRIES-1:0]            en,
    input  cmd_t                            cmd,
    input  logic [MAC_W-1:0]                addr,
    output logic                            accept
);
    logic [N_ENTRIES-1:0] hit_vec;

    for (genvar k = 0; k < N_ENTRIES; k++) begin : g_cmp
        assign hit_vec[k] = en[k] && (ent[k] == addr);
    end

    always_comb begin
        accept = decide(cmd, classify(addr), |hit_vec);
    end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
    import dafilt_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int REG_AW    = $clog2(2 * N_ENTRIES + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [7:0]        in_byte,
    output logic              dec_valid,
    output logic              dec_accept
);
    logic [N_ENTRIES-1:0][MAC_W-1:0] act_ent;
    logic [N_ENTRIES-1:0]            act_en;
    cmd_t                            act_cmd;
    logic [MAC_W-1:0]                addr_full;
    logic                            addr_done;
    logic                            acc_now;
    logic                            start;

    assign start = in_valid && in_sof;

    dafilt_regs #(.N_ENTRIES(N_ENTRIES), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .snap(start),
        .act_ent(act_ent), .act_en(act_en), .act_cmd(act_cmd)
    );

    dafilt_capture u_cap (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_byte(in_byte), .addr_full(addr_full), .addr_done(addr_done)
    );

    dafilt_match #(.N_ENTRIES(N_ENTRIES)) u_match (
        .ent(act_ent), .en(act_en), .cmd(act_cmd),
        .addr(addr_full), .accept(acc_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid <= addr_done;
            if (start)          dec_accept <= 1'b0;
            else if (addr_done) dec_accept <= acc_now;
        end
    end
endmodule

// File: rtl/dafilt_checker.sv
module dafilt_checker (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_sof,
    input logic dec_valid,
    input logic dec_accept
);
    // R7: the strobe lasts a single cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid);

    // R7: the result moves only with a strobe or after a start byte
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(dec_accept) |-> (dec_valid || $past(in_valid && in_sof)));

    // R8: a decision needs a byte taken in the cycle before
    a_r8_byte_before: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $past(in_valid && !in_sof));

    // R7: accept rises only together with the strobe
    a_r7_rise_with_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(dec_accept) |-> dec_valid);

    // R7: a start byte clears the previous result
    a_r7_sof_clears: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sof) |=> !dec_accept);
endmodule

bind dest_addr_filter dafilt_checker u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
);

// File: tb/dest_addr_filter_bench.sv
module dest_addr_filter_bench;
    localparam int N = 16;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          in_valid = 1'b0;
    logic          in_sof = 1'b0;
    logic [7:0]    in_byte = '0;
    logic          dec_valid;
    logic          dec_accept;

    always #2 clk = ~clk;

    dest_addr_filter #(.N_ENTRIES(N)) u_dest_addr_filter (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .in_valid(in_valid), .in_sof(in_sof),
        .in_byte(in_byte), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    // reference model state
    logic [47:0] m_ent [N];
    logic [47:0] s_ent [N];
    logic [N-1:0] m_en, s_en;
    logic [4:0]  m_cmd, s_cmd;
    logic [7:0]  mq [$];
    bit          m_active;
    bit          exp_valid, exp_acc;

    int    vectors = 0;
    int    fails = 0;
    bit    finished = 0;
    string tag = "R1";

    function automatic bit model_decide(logic [47:0] a);
        bit hit, bc, mc, uc;
        hit = 0;
        for (int i = 0; i < N; i++)
            if (s_en[i] && s_ent[i] == a) hit = 1;
        bc = (a == 48'hFFFF_FFFF_FFFF);
        mc = !bc && a[40];
        uc = !a[40];
        return (s_cmd[0] && uc) || (s_cmd[1] && mc) || (s_cmd[2] && bc) ||
               (s_cmd[4] && (hit ^ s_cmd[3]));
    endfunction

    task automatic check_out();
        vectors++;
        if (dec_valid !== exp_valid || dec_accept !== exp_acc) begin
            fails++;
            $display("FAIL %s valid/accept got %b/%b expected %b/%b at %0t",
                     tag, dec_valid, dec_accept, exp_valid, exp_acc, $time);
        end
    endtask

    task automatic step(input bit v, input bit s, input logic [7:0] b,
                        input bit w, input logic [AW-1:0] a, input logic [31:0] d);
        logic [47:0] full;
        @(negedge clk);
        in_valid = v; in_sof = s; in_byte = b;
        reg_wr = w; reg_addr = a; reg_wdata = d;
        exp_valid = 0;
        if (v && s) begin
            for (int i = 0; i < N; i++) s_ent[i] = m_ent[i];
            s_en = m_en; s_cmd = m_cmd;
            mq.delete(); mq.push_back(b);
            m_active = 1; exp_acc = 0;
        end else if (v && m_active) begin
            mq.push_back(b);
            if (mq.size() == 6) begin
                full = {mq[0], mq[1], mq[2], mq[3], mq[4], mq[5]};
                exp_valid = 1;
                exp_acc = model_decide(full);
                m_active = 0;
            end
        end
        if (w) begin
            if (int'(a) < 2 * N) begin
                if (a[0] == 1'b0) m_ent[a / 2][47:16] = d;
                else              m_ent[a / 2][15:0]  = d[31:16];
            end else if (int'(a) == 2 * N) m_en = d[N-1:0];
            else if (int'(a) == 2 * N + 1) m_cmd = d[4:0];
        end
        @(posedge clk);
        #1 check_out();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0, '0, '0);
    endtask

    task automatic wreg(input int a, input logic [31:0] d);
        step(0, 0, 8'h00, 1, AW'(a), d);
    endtask

    task automatic load_entry(input int k, input logic [47:0] mac);
        wreg(2 * k, mac[47:16]);
        wreg(2 * k + 1, {mac[15:0], 16'h0000});
    endtask

    task automatic frame(input logic [47:0] mac);
        for (int i = 0; i < 6; i++)
            step(1, i == 0, mac[47 - 8 * i -: 8], 0, '0, '0);
        idle(2);
    endtask

    localparam logic [47:0] MAC_A = 48'h02_11_22_33_44_55;
    localparam logic [47:0] MAC_B = 48'h00_A0_B1_C2_D3_E4;
    localparam logic [47:0] MAC_M = 48'h01_00_5E_00_00_07;
    localparam logic [47:0] MAC_BC = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] MAC_Z = 48'h04_99_88_77_66_55;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_ent[i] = '0; s_ent[i] = '0; end
        m_en = '0; s_en = '0; m_cmd = '0; s_cmd = '0;
        m_active = 0; exp_valid = 0; exp_acc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(posedge clk);
        #1 tag = "R1"; check_out();
        frame(MAC_A);              // R1: nothing programmed, rejected
        frame(MAC_BC);

        tag = "R2";
        load_entry(0, MAC_A);
        wreg(2 * N, 32'h0000_0001);
        wreg(2 * N + 1, 32'h10);
        frame(MAC_A);
        frame(MAC_B);
        frame(MAC_A ^ 48'h1);      // last byte differs

        tag = "R10";
        load_entry(15, MAC_B);
        wreg(2 * N, 32'h0000_8001);
        frame(MAC_B);

        tag = "R3";
        wreg(2 * N, 32'h0000_8000);
        frame(MAC_A);
        frame(MAC_B);

        tag = "R4";
        wreg(2 * N + 1, 32'h01);
        frame(MAC_Z); frame(MAC_M); frame(MAC_BC);
        wreg(2 * N + 1, 32'h02);
        frame(MAC_Z); frame(MAC_M); frame(MAC_BC);
        wreg(2 * N + 1, 32'h04);
        frame(MAC_Z); frame(MAC_M); frame(MAC_BC);

        tag = "R5";
        wreg(2 * N, 32'h0000_0001);
        wreg(2 * N + 1, 32'h18);
        frame(MAC_A); frame(MAC_Z);

        tag = "R6";
        wreg(2 * N + 1, 32'h08);
        frame(MAC_A); frame(MAC_Z);
        wreg(2 * N + 1, 32'h00);
        frame(MAC_A);

        tag = "R8";
        wreg(2 * N + 1, 32'h10);
        step(1, 1, 8'hAA, 0, '0, '0);
        step(1, 0, 8'hBB, 0, '0, '0);
        step(1, 0, 8'hCC, 0, '0, '0);
        frame(MAC_A);              // restart mid-address
        for (int i = 0; i < 6; i++) begin
            step(1, i == 0, MAC_A[47 - 8 * i -: 8], 0, '0, '0);
            step(0, 0, 8'hEE, 0, '0, '0);   // gap byte ignored
        end
        step(1, 0, 8'h12, 0, '0, '0);       // after sixth: ignored
        step(1, 0, 8'h34, 0, '0, '0);
        idle(3);

        tag = "R9";
        step(1, 1, MAC_A[47:40], 0, '0, '0);
        step(1, 0, MAC_A[39:32], 1, AW'(2 * N), 32'h0);   // disable mid-frame
        for (int i = 2; i < 6; i++) step(1, 0, MAC_A[47 - 8 * i -: 8], 0, '0, '0);
        idle(2);
        frame(MAC_A);               // now rejected
        // write in the same cycle as start byte
        step(1, 1, MAC_A[47:40], 1, AW'(2 * N), 32'h1);
        for (int i = 1; i < 6; i++) step(1, 0, MAC_A[47 - 8 * i -: 8], 0, '0, '0);
        idle(2);
        frame(MAC_A);

        tag = "R7";
        frame(MAC_A);
        idle(5);
        step(1, 1, 8'h00, 0, '0, '0);
        idle(3);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule